// File: doc/BRIEF.md
# Masked I/O change-of-state interrupt controller

This block watches twelve general-purpose I/O lines and three internal alarm or event sources, and merges them into one interrupt request. Each line passes through a two-flop synchronizer. The block then compares the line's level with the last level it accepted. A change on a line configured as an input can interrupt only when both the line's own mask bit and the mask bit of its channel are clear. Lines are grouped into four channels of three lines each. A line that drives an output never interrupts. Each line can optionally go through a persistency filter. The filter accepts a new level only after it has stayed stable for a programmed number of prescaler ticks. An unfiltered line reports a change at once.

Every qualified event sets a sticky pending bit, and the interrupt output is the OR of all pending bits. Software reads the pending bits and clears them by writing ones. All masks, hold times and pending bits sit in a small byte-wide register space. Reads are combinational on the address, and writes take effect on the clock edge when the write strobe is high.

Top module: `gpio_chg_irq`

## Requirements
- R1: After reset, the line masks read as all ones (11h = FFh, 12h = 0Fh), the group mask reads 7Fh, the hold-time registers read 00h, every pending register reads 00h and `irq_o` is low.
- R2: Register map. 11h holds the line masks for lines 7..0, one bit per line. 12h bits 3..0 hold the line masks for lines 11..8. 13h holds the group mask: bits 3..0 mask channels 3..0, bit 4 masks clock-fail, bit 5 masks the PCM event and bit 6 masks timing-violation. 18h+g holds the hold time of channel g. 20h and 21h (bits 3..0) hold the line pending bits, with the same bit layout as the line masks. 22h holds the alarm pending bits at bits 4 (clock-fail), 5 (PCM) and 6 (timing-violation). Any other address reads 00h.
- R3: Bits 7..4 of 12h and bit 7 of 13h always read 0, and writes to them have no effect.
- R4: A change on an unfiltered input line whose line mask and channel mask are both 0 sets its pending bit. The bit becomes visible after the third rising edge that follows the pin change.
- R5: A line mask bit of 1 blocks the line. A change seen while the line is blocked is consumed and does not interrupt later when the mask is cleared.
- R6: Channel c covers lines 3c..3c+2. If a channel's mask bit is 1, its lines cannot interrupt, whatever their line masks say.
- R7: A line with `line_is_out` high never sets its pending bit.
- R8: A filtered line reports a new level only after the synchronized level has differed from the last accepted level, without toggling, for hold+1 prescaler ticks. A tick occurs every TICK_DIV cycles. A return to the accepted level cancels the count, and a toggle restarts it.
- R9: In any cycle where an alarm source is high and its mask bit is 0, that source's pending bit is set.
- R10: Pending bits are sticky and are cleared by writing 1 to them. If an event and a clear of the same bit fall in the same cycle, the bit stays set.
- R11: `irq_o` is high exactly when at least one pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 12 | I/O line levels, asynchronous |
| line_is_out | input | 12 | 1 = line configured as an output |
| filt_en | input | 12 | 1 = persistency filter enabled for the line |
| alarm_clkfail | input | 1 | Clock-fail alarm, synchronous |
| alarm_timing | input | 1 | Timing-violation alarm, synchronous |
| pcm_event | input | 1 | PCM event, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on `reg_addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
A source event and a write-one-to-clear of the same pending bit can fall on the same clock edge. The bench provokes this by raising the PCM event in the very cycle that writes 1 to its pending bit. It then judges that the bit and `irq_o` stay set. A masked line change and a mask write can also meet in one cycle. For that case, the bench clears the masks after a line has changed and confirms that the consumed change never reaches the pending register. Both cases are compared every cycle against a behavioural reference model.

// File: rtl/gcirq_pkg.sv
package gcirq_pkg;
  localparam int unsigned NLINES = 12;
  localparam int unsigned LPG    = 3;
  localparam int unsigned NGRP   = NLINES / LPG;
  localparam int unsigned HOLD_W = 8;
  localparam int unsigned NALARM = 3;

  localparam logic [7:0] A_LMASK_LO = 8'h11;
  localparam logic [7:0] A_LMASK_HI = 8'h12;
  localparam logic [7:0] A_GMASK    = 8'h13;
  localparam logic [7:0] A_HOLD0    = 8'h18;
  localparam logic [7:0] A_PEND_LO  = 8'h20;
  localparam logic [7:0] A_PEND_HI  = 8'h21;
  localparam logic [7:0] A_PEND_AL  = 8'h22;

  typedef struct packed {
    logic            tv;
    logic            pcm;
    logic            cf;
    logic [NGRP-1:0] chan;
  } gmask_t;
endpackage

// File: rtl/gcirq_tick.sv
module gcirq_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/gcirq_lane.sv
module gcirq_lane #(
  parameter int unsigned HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic          filt,
  input  logic          tick,
  input  logic [HW-1:0] hold,
  output logic          evt
);
  logic          sy1_q, sy2_q, sd_q, ref_q, ref_d;
  logic [HW-1:0] cnt_q, cnt_d;

  // Accept a new level at once, or after hold+1 stable ticks when filtered
  always_comb begin
    ref_d = ref_q;
    cnt_d = '0;
    evt   = 1'b0;
    if (sy2_q != ref_q) begin
      if (!filt) begin
        evt   = 1'b1;
        ref_d = sy2_q;
      end else if (sy2_q != sd_q) begin
        cnt_d = '0;
      end else if (tick) begin
        if (cnt_q == hold) begin
          evt   = 1'b1;
          ref_d = sy2_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = cnt_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= 1'b0;
      sy2_q <= 1'b0;
      sd_q  <= 1'b0;
      ref_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      sy1_q <= pin;
      sy2_q <= sy1_q;
      sd_q  <= sy2_q;
      ref_q <= ref_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/gcirq_regs.sv
module gcirq_regs
  import gcirq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [7:0]             addr,
  input  logic [7:0]             wdata,
  output logic [NLINES-1:0]      lmask,
  output gmask_t                 gmask,
  output logic [NGRP*HOLD_W-1:0] hold
);
  logic [NLINES-1:0]      lmask_d;
  gmask_t                 gmask_d;
  logic [NGRP*HOLD_W-1:0] hold_d;

  always_comb begin
    lmask_d = lmask;
    gmask_d = gmask;
    hold_d  = hold;
    if (wr) begin
      if (addr == A_LMASK_LO) lmask_d[7:0]        = wdata;
      if (addr == A_LMASK_HI) lmask_d[NLINES-1:8] = wdata[NLINES-9:0];
      if (addr == A_GMASK)    gmask_d             = gmask_t'(wdata[$bits(gmask_t)-1:0]);
      for (int g = 0; g < int'(NGRP); g++) begin
        if (addr == A_HOLD0 + 8'(g)) hold_d[g*HOLD_W +: HOLD_W] = wdata[HOLD_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lmask <= '1;
      gmask <= '1;
      hold  <= '0;
    end else begin
      lmask <= lmask_d;
      gmask <= gmask_d;
      hold  <= hold_d;
    end
  end
endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq
  import gcirq_pkg::*;
#(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] line_in,
  input  logic [11:0] line_is_out,
  input  logic [11:0] filt_en,
  input  logic        alarm_clkfail,
  input  logic        alarm_timing,
  input  logic        pcm_event,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq_o
);
  logic                   rst_meta, rst_q;
  logic                   tick;
  logic [NLINES-1:0]      lmask, chan_blk, evt_raw, line_hit;
  gmask_t                 gmask;
  logic [NGRP*HOLD_W-1:0] hold_flat;
  logic [NLINES-1:0]      pend_line_q, pend_line_d, clr_line;
  logic [NALARM-1:0]      pend_al_q, pend_al_d, clr_al, al_hit;

  // Reset asserts at once, releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_q, rst_meta} <= 2'b00;
    else        {rst_q, rst_meta} <= {rst_meta, 1'b1};
  end

  gcirq_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_q), .tick(tick));

  gcirq_regs u_regs (
    .clk(clk), .rst_n(rst_q), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .lmask(lmask), .gmask(gmask), .hold(hold_flat)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_lane
    gcirq_lane #(.HW(HOLD_W)) u_lane (
      .clk(clk), .rst_n(rst_q), .pin(line_in[i]), .filt(filt_en[i]), .tick(tick),
      .hold(hold_flat[(i/LPG)*HOLD_W +: HOLD_W]), .evt(evt_raw[i])
    );
    assign chan_blk[i] = gmask.chan[i/LPG];
  end

  assign line_hit = evt_raw & ~line_is_out & ~lmask & ~chan_blk;
  assign al_hit   = {alarm_timing & ~gmask.tv, pcm_event & ~gmask.pcm, alarm_clkfail & ~gmask.cf};

  always_comb begin
    clr_line = '0;
    clr_al   = '0;
    if (reg_wr) begin
      if (reg_addr == A_PEND_LO) clr_line[7:0]        = reg_wdata;
      if (reg_addr == A_PEND_HI) clr_line[NLINES-1:8] = reg_wdata[NLINES-9:0];
      if (reg_addr == A_PEND_AL) clr_al               = reg_wdata[4 +: NALARM];
    end
    pend_line_d = (pend_line_q & ~clr_line) | line_hit;
    pend_al_d   = (pend_al_q & ~clr_al) | al_hit;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pend_line_q <= '0;
      pend_al_q   <= '0;
    end else begin
      pend_line_q <= pend_line_d;
      pend_al_q   <= pend_al_d;
    end
  end

  assign irq_o = |{pend_line_q, pend_al_q};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_LMASK_LO: reg_rdata = lmask[7:0];
      A_LMASK_HI: reg_rdata[NLINES-9:0] = lmask[NLINES-1:8];
      A_GMASK:    reg_rdata[$bits(gmask_t)-1:0] = gmask;
      A_PEND_LO:  reg_rdata = pend_line_q[7:0];
      A_PEND_HI:  reg_rdata[NLINES-9:0] = pend_line_q[NLINES-1:8];
      A_PEND_AL:  reg_rdata[4 +: NALARM] = pend_al_q;
      default: begin
        for (int g = 0; g < int'(NGRP); g++) begin
          if (reg_addr == A_HOLD0 + 8'(g)) reg_rdata[HOLD_W-1:0] = hold_flat[g*HOLD_W +: HOLD_W];
        end
      end
    endcase
  end
endmodule

// File: rtl/gcirq_chk.sv
module gcirq_chk
  import gcirq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [NLINES-1:0] filt_en,
  input logic [NLINES-1:0] evt_raw,
  input logic [NLINES-1:0] line_hit,
  input logic [NLINES-1:0] line_is_out,
  input logic [NLINES-1:0] lmask,
  input logic [NGRP-1:0]   chan_mask,
  input logic              cf_mask,
  input logic              alarm_clkfail,
  input logic [NLINES-1:0] pend_line,
  input logic              pend_cf,
  input logic              reg_wr,
  input logic [7:0]        reg_addr,
  input logic [7:0]        reg_wdata
);
  logic [NLINES-1:0] blk;
  always_comb begin
    for (int i = 0; i < int'(NLINES); i++) blk[i] = chan_mask[i/LPG];
  end

  // R7
  pend_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_line & ~$past(pend_line)) & $past(line_is_out | lmask | blk)) == '0);

  // R10
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr) && $past(reg_addr) == A_PEND_LO) |->
      (pend_line[7:0] & $past(reg_wdata) & ~$past(line_hit[7:0])) == 8'h00);

  // R10
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend_line) & ~pend_line)) |->
      ($past(reg_wr) && ($past(reg_addr) == A_PEND_LO || $past(reg_addr) == A_PEND_HI)));

  // R9
  cf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_cf) |-> $past(alarm_clkfail && !cf_mask));

  // R8
  filt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_raw & filt_en & ~{NLINES{tick}}) == '0);
endmodule

bind gpio_chg_irq gcirq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .filt_en(filt_en), .evt_raw(evt_raw),
  .line_hit(line_hit), .line_is_out(line_is_out), .lmask(lmask),
  .chan_mask(gmask.chan), .cf_mask(gmask.cf), .alarm_clkfail(alarm_clkfail),
  .pend_line(pend_line_q), .pend_cf(pend_al_q[0]),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/gpio_chg_irq_tb.sv
module gpio_chg_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] line_in, line_is_out, filt_en;
  logic        alarm_clkfail, alarm_timing, pcm_event;
  logic        reg_wr;
  logic [7:0]  reg_addr, reg_wdata, reg_rdata;
  logic        irq_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_chg_irq #(.TICK_DIV(TICK_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_is_out(line_is_out),
    .filt_en(filt_en), .alarm_clkfail(alarm_clkfail), .alarm_timing(alarm_timing),
    .pcm_event(pcm_event), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // Behavioural reference model
  bit [11:0] m_sy1, m_sy2, m_sd, m_ref, m_lmask, m_pl;
  int        m_cnt [12];
  bit [7:0]  m_hold [4];
  bit [6:0]  m_gm;
  bit [2:0]  m_pa;
  int        m_pc, m_rs;

  task automatic model_step();
    bit tk;
    bit [11:0] hit, clr;
    bit [2:0] ahit, aclr;
    tk = (m_pc == TICK_DIV - 1);
    hit = '0; clr = '0; aclr = '0;
    for (int i = 0; i < 12; i++) begin
      bit ev;
      ev = 1'b0;
      if (m_sy2[i] != m_ref[i]) begin
        if (!filt_en[i]) begin
          ev = 1'b1; m_ref[i] = m_sy2[i]; m_cnt[i] = 0;
        end else if (m_sy2[i] != m_sd[i]) begin
          m_cnt[i] = 0;
        end else if (tk) begin
          if (m_cnt[i] == int'(m_hold[i/3])) begin
            ev = 1'b1; m_ref[i] = m_sy2[i]; m_cnt[i] = 0;
          end else m_cnt[i]++;
        end
      end else m_cnt[i] = 0;
      hit[i] = ev && !line_is_out[i] && !m_lmask[i] && !m_gm[i/3];
    end
    ahit = {alarm_timing && !m_gm[6], pcm_event && !m_gm[5], alarm_clkfail && !m_gm[4]};
    if (reg_wr) begin
      case (reg_addr)
        8'h11: m_lmask[7:0]  = reg_wdata;
        8'h12: m_lmask[11:8] = reg_wdata[3:0];
        8'h13: m_gm          = reg_wdata[6:0];
        8'h18, 8'h19, 8'h1A, 8'h1B: m_hold[reg_addr - 8'h18] = reg_wdata;
        8'h20: clr[7:0]  = reg_wdata;
        8'h21: clr[11:8] = reg_wdata[3:0];
        8'h22: aclr      = reg_wdata[6:4];
        default: ;
      endcase
    end
    m_pl = (m_pl & ~clr) | hit;
    m_pa = (m_pa & ~aclr) | ahit;
    m_pc = tk ? 0 : m_pc + 1;
    m_sd = m_sy2; m_sy2 = m_sy1; m_sy1 = line_in;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sy1 = '0; m_sy2 = '0; m_sd = '0; m_ref = '0; m_pl = '0; m_pa = '0;
      m_lmask = '1; m_gm = '1; m_pc = 0; m_rs = 0;
      for (int i = 0; i < 12; i++) m_cnt[i] = 0;
      for (int g = 0; g < 4; g++) m_hold[g] = '0;
    end else if (m_rs < 2) m_rs++;
    else model_step();
  end

  function automatic logic [7:0] mread(logic [7:0] a);
    case (a)
      8'h11: return m_lmask[7:0];
      8'h12: return {4'h0, m_lmask[11:8]};
      8'h13: return {1'b0, m_gm};
      8'h18, 8'h19, 8'h1A, 8'h1B: return m_hold[a - 8'h18];
      8'h20: return m_pl[7:0];
      8'h21: return {4'h0, m_pl[11:8]};
      8'h22: return {1'b0, m_pa, 4'h0};
      default: return 8'h00;
    endcase
  endfunction

  // Compare every cycle
  always @(negedge clk) begin
    #1;
    if (!done) begin
      vectors++;
      if (irq_o !== (|{m_pl, m_pa})) begin
        fails++;
        $display("FAIL R11 irq_o actual=%0b expected=%0b", irq_o, |{m_pl, m_pa});
      end
      if (reg_rdata !== mread(reg_addr)) begin
        fails++;
        $display("FAIL R2 rdata@%02h actual=%02h expected=%02h", reg_addr, reg_rdata, mread(reg_addr));
      end
    end
  end

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #2;
    chk(tag, reg_rdata, exp);
    chk(tag, reg_rdata, mread(a));
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    line_in = '0; line_is_out = '0; filt_en = '0;
    alarm_clkfail = 1'b0; alarm_timing = 1'b0; pcm_event = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    idle(5);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd("R1 lmask_lo", 8'h11, 8'hFF);
    rd("R1 lmask_hi", 8'h12, 8'h0F);
    rd("R1 gmask", 8'h13, 8'h7F);
    rd("R1 hold0", 8'h18, 8'h00);
    rd("R1 pend_lo", 8'h20, 8'h00);
    rd("R1 pend_al", 8'h22, 8'h00);
    chk("R1 irq", {7'h0, irq_o}, 8'h00);

    // R3 unused bits
    wr(8'h12, 8'hF0);
    rd("R3 lmask_hi", 8'h12, 8'h00);
    wr(8'h12, 8'hFF);
    rd("R3 lmask_hi", 8'h12, 8'h0F);
    wr(8'h13, 8'hFF);
    rd("R3 gmask", 8'h13, 8'h7F);

    // R5 masked change is consumed
    line_in[0] = 1'b1;
    idle(6);
    rd("R5 masked", 8'h20, 8'h00);
    wr(8'h11, 8'h00);
    wr(8'h12, 8'h00);
    wr(8'h13, 8'h70);
    rd("R2 lmask_lo", 8'h11, 8'h00);
    rd("R2 gmask", 8'h13, 8'h70);
    idle(4);
    rd("R5 consumed", 8'h20, 8'h00);

    // R4 unfiltered change, R11 irq
    line_in[1] = 1'b1;
    idle(5);
    rd("R4 pend line1", 8'h20, 8'h02);
    chk("R11 irq set", {7'h0, irq_o}, 8'h01);
    wr(8'h20, 8'h02);
    rd("R10 cleared", 8'h20, 8'h00);
    chk("R11 irq clear", {7'h0, irq_o}, 8'h00);

    // R6 channel 1 masked
    wr(8'h13, 8'h72);
    line_in[4] = 1'b1;
    line_in[7] = 1'b1;
    idle(5);
    rd("R6 chan block", 8'h20, 8'h80);
    wr(8'h20, 8'h80);

    // R7 output line
    line_is_out[10] = 1'b1;
    line_in[10] = 1'b1;
    idle(5);
    rd("R7 out line", 8'h21, 8'h00);
    line_is_out[10] = 1'b0;
    line_in[11] = 1'b1;
    idle(5);
    rd("R4 line11", 8'h21, 8'h08);
    wr(8'h21, 8'h08);

    // R8 persistency filter on line 9, hold 3
    wr(8'h1B, 8'h03);
    rd("R2 hold3", 8'h1B, 8'h03);
    filt_en[9] = 1'b1;
    line_in[9] = 1'b1;
    idle(3);
    line_in[9] = 1'b0;
    idle(30);
    rd("R8 glitch", 8'h21, 8'h00);
    line_in[9] = 1'b1;
    idle(10);
    rd("R8 not yet", 8'h21, 8'h00);
    idle(12);
    rd("R8 held", 8'h21, 8'h02);
    wr(8'h21, 8'h02);
    line_in[9] = 1'b0;
    idle(8);
    line_in[9] = 1'b1;
    idle(2);
    line_in[9] = 1'b0;
    idle(30);
    rd("R8 restart", 8'h21, 8'h02);
    wr(8'h21, 8'h02);

    // R9 alarms
    wr(8'h13, 8'h40);
    @(negedge clk);
    alarm_clkfail = 1'b1; alarm_timing = 1'b1;
    @(negedge clk);
    alarm_clkfail = 1'b0; alarm_timing = 1'b0;
    rd("R9 clkfail", 8'h22, 8'h10);
    wr(8'h22, 8'h10);
    @(negedge clk);
    pcm_event = 1'b1;
    @(negedge clk);
    pcm_event = 1'b0;
    rd("R9 pcm", 8'h22, 8'h20);

    // R10 event and clear in the same cycle
    @(negedge clk);
    pcm_event = 1'b1;
    reg_wr = 1'b1; reg_addr = 8'h22; reg_wdata = 8'h20;
    @(negedge clk);
    pcm_event = 1'b0; reg_wr = 1'b0;
    rd("R10 set wins", 8'h22, 8'h20);
    chk("R11 irq held", {7'h0, irq_o}, 8'h01);
    wr(8'h22, 8'h20);
    rd("R10 clear", 8'h22, 8'h00);

    rd("R2 unused addr", 8'h30, 8'h00);
    idle(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule